// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. Its clock is the output of a fixed divide-by-8 prescaler that sits ahead of it. The block divides that clock by N = 32·M + S and issues one single-cycle pulse per division period to the phase comparator, so the synthesized frequency is the reference frequency × 8 × (32·M + S).

Inside, a modulus stage counts either 33 or 32 input clocks per segment. A swallow counter makes the first S segments of each period 33 clocks long, and a main counter ends the period after M segments. Both operands are plain binary values. A mode input narrows the main operand to 9 bits for the 14-bit divider configuration. An effective M below 32 is raised to 32, which keeps every period longer than its swallow portion.

New operands are taken only when one period ends and the next begins, so every period has exactly the length its operands define.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst` is high, `div_pulse` is 0. The first `div_pulse` appears at the N-th rising edge of `clk` counted from the first edge at which `rst` is low. N is computed from the operands present during reset.
- R2: In wide mode (`narrow_mode` = 0), consecutive `div_pulse` assertions are exactly 32·M + S clock edges apart, where M = `div_m` (10-bit binary, 32..1023) and S = `div_s` (5-bit binary, 0..31), including the extreme values S = 0 and S = 31.
- R3: In narrow mode (`narrow_mode` = 1), bit 9 of `div_m` is ignored and M = `div_m[8:0]`, giving a period of 32·`div_m[8:0]` + S.
- R4: An effective M below 32 (after the narrow-mode masking of R3) is treated as 32.
- R5: `div_pulse` is high for exactly one clock cycle per period.
- R6: `div_m`, `div_s` and `narrow_mode` are sampled only at the edge that raises `div_pulse` (the end of a period) and while in reset. Changes made between those edges do not alter the length of the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled clock; every rising edge is one count |
| rst | input | 1 | Synchronous active-high reset |
| div_m | input | 10 | Main ratio M, binary |
| div_s | input | 5 | Swallow ratio S, binary |
| narrow_mode | input | 1 | 1 selects the 9-bit main ratio |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |

## Verification
The main division is run with the smallest ratio (M = 32, S = 0), the same M with the largest swallow count (S = 31), a mid-range pair, and the largest ratio (M = 1023, S = 31). Together these separate a correct 33/32 segment mix from a single-modulus count and from an off-by-one on either counter. Narrow-mode vectors with bit 9 set show that the top bit is masked rather than honoured. A sub-32 operand in each mode shows the clamp acting after the mask. An operand change that is applied mid-period and withdrawn before the period ends shows that operands are sampled only at period ends.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  parameter int unsigned PSW_M_W   = 10;
  parameter int unsigned PSW_S_W   = 5;
  parameter int unsigned PSW_M_MIN = 32;
endpackage

// File: rtl/pswallow_operand.sv
module pswallow_operand #(
  parameter int unsigned M_W   = pswallow_pkg::PSW_M_W,
  parameter int unsigned S_W   = pswallow_pkg::PSW_S_W,
  parameter int unsigned M_MIN = pswallow_pkg::PSW_M_MIN
) (
  input  logic [M_W-1:0] m_raw,
  input  logic [S_W-1:0] s_raw,
  input  logic           narrow,
  output logic [M_W-1:0] m_eff,
  output logic [S_W-1:0] s_eff
);
  localparam logic [M_W-1:0] MIN_V = M_W'(M_MIN);

  logic [M_W-1:0] m_sel;

  // narrow mode drops the top bit of the main ratio
  always_comb begin
    m_sel = m_raw;
    if (narrow) m_sel[M_W-1] = 1'b0;
  end

  assign m_eff = (m_sel < MIN_V) ? MIN_V : m_sel;
  assign s_eff = s_raw;
endmodule

// File: rtl/pswallow_modulus.sv
module pswallow_modulus #(
  parameter int unsigned S_W = pswallow_pkg::PSW_S_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         high_mod,
  output logic         seg_end,
  output logic [S_W:0] seg_cnt
);
  localparam logic [S_W:0] LIM_LO = (S_W+1)'((1 << S_W) - 1);
  localparam logic [S_W:0] LIM_HI = (S_W+1)'(1 << S_W);

  assign seg_end = (seg_cnt == (high_mod ? LIM_HI : LIM_LO));

  always_ff @(posedge clk) begin
    if (rst)          seg_cnt <= '0;
    else if (seg_end) seg_cnt <= '0;
    else              seg_cnt <= seg_cnt + 1'b1;
  end

  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (rst)
    seg_cnt <= LIM_HI); // R2
  AST_SEG_HIGH_ONLY_SWALLOW: assert property (@(posedge clk) disable iff (rst)
    (seg_cnt == LIM_HI) |-> high_mod); // R2
endmodule

// File: rtl/pswallow_period.sv
module pswallow_period #(
  parameter int unsigned M_W = pswallow_pkg::PSW_M_W,
  parameter int unsigned S_W = pswallow_pkg::PSW_S_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           seg_end,
  input  logic [M_W-1:0] m_eff,
  input  logic [S_W-1:0] s_eff,
  output logic           high_mod,
  output logic           last_cnt,
  output logic           pulse_q
);
  logic [M_W-1:0] main_left;
  logic [S_W-1:0] swal_left;

  assign high_mod = (swal_left != '0);
  assign last_cnt = seg_end && (main_left == M_W'(1));

  always_ff @(posedge clk) begin
    if (rst || last_cnt) begin
      main_left <= m_eff;
      swal_left <= s_eff;
    end else if (seg_end) begin
      main_left <= main_left - 1'b1;
      if (high_mod) swal_left <= swal_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= last_cnt;
  end

  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    main_left != '0); // R4
  AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (rst)
    M_W'(swal_left) < main_left); // R2
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R5
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int unsigned M_W   = pswallow_pkg::PSW_M_W,
  parameter int unsigned S_W   = pswallow_pkg::PSW_S_W,
  parameter int unsigned M_MIN = pswallow_pkg::PSW_M_MIN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] div_m,
  input  logic [S_W-1:0] div_s,
  input  logic           narrow_mode,
  output logic           div_pulse
);
  logic [M_W-1:0] m_eff;
  logic [S_W-1:0] s_eff;
  logic           high_mod;
  logic           seg_end;
  logic [S_W:0]   seg_cnt;
  logic           last_cnt;

  pswallow_operand #(.M_W(M_W), .S_W(S_W), .M_MIN(M_MIN)) u_opnd (
    .m_raw(div_m), .s_raw(div_s), .narrow(narrow_mode),
    .m_eff(m_eff), .s_eff(s_eff)
  );

  pswallow_modulus #(.S_W(S_W)) u_mod (
    .clk(clk), .rst(rst), .high_mod(high_mod),
    .seg_end(seg_end), .seg_cnt(seg_cnt)
  );

  pswallow_period #(.M_W(M_W), .S_W(S_W)) u_per (
    .clk(clk), .rst(rst), .seg_end(seg_end), .m_eff(m_eff), .s_eff(s_eff),
    .high_mod(high_mod), .last_cnt(last_cnt), .pulse_q(div_pulse)
  );

  AST_PULSE_AT_RESTART: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (seg_cnt == '0)); // R6
  AST_NO_PULSE_IN_RESET: assert property (@(posedge clk)
    $past(rst) |-> !div_pulse); // R1
endmodule

// File: tb/pswallow_divider_test.sv
module pswallow_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] div_m = 10'd40;
  logic [4:0] div_s = 5'd4;
  logic       narrow_mode = 1'b0;
  logic       div_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam int NV = 8;
  localparam int VM  [NV] = '{32, 32, 100, 1023, 600, 10, 511, 520};
  localparam int VS  [NV] = '{0, 31, 7, 31, 5, 3, 0, 1};
  localparam int VN  [NV] = '{0, 0, 0, 0, 1, 0, 1, 1};
  localparam int VEX [NV] = '{1024, 1055, 3207, 32767, 2821, 1027, 16352, 1025};
  localparam int LIMIT = 40000;

  pswallow_divider uut (
    .clk(clk), .rst(rst), .div_m(div_m), .div_s(div_s),
    .narrow_mode(narrow_mode), .div_pulse(div_pulse)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts edges until the next pulse; the edge after a pulse must be low (R5)
  task automatic gap(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      if (n == 1) check(div_pulse == 1'b0, "R5 pulse width", int'(div_pulse), 0);
    end while (!div_pulse && n < LIMIT);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(posedge clk);
    #1;
    check(div_pulse == 1'b0, "R1 reset state", int'(div_pulse), 0);
    @(negedge clk);
    rst = 1'b0;
    gap(n);
    check(n == 1284, "R1 first period after reset", n, 1284);

    // R6: change M mid-period and restore it before the period ends
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      if (n == 200) div_m = 10'd100;
      if (n == 400) div_m = 10'd40;
    end while (!div_pulse && n < LIMIT);
    check(n == 1284, "R6 mid-period change ignored", n, 1284);

    // R6: a change held past the period end applies only from the next period
    div_m = 10'd32; div_s = 5'd0;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      if (n == 300) div_m = 10'd33;
    end while (!div_pulse && n < LIMIT);
    check(n == 1284, "R6 period in progress keeps old length", n, 1284);
    gap(n);
    check(n == 1056, "R6 new operands from next period", n, 1056);

    for (int i = 0; i < NV; i++) begin
      div_m = 10'(VM[i]); div_s = 5'(VS[i]); narrow_mode = VN[i][0];
      gap(n);
      gap(n);
      if (VN[i] == 1)
        check(n == VEX[i], "R3 narrow-mode period", n, VEX[i]);
      else if (VM[i] < 32)
        check(n == VEX[i], "R4 clamped period", n, VEX[i]);
      else
        check(n == VEX[i], "R2 wide-mode period", n, VEX[i]);
    end

    // R1 again: reset mid-period, operands held during reset
    @(negedge clk);
    rst = 1'b1; div_m = 10'd5; div_s = 5'd2; narrow_mode = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(div_pulse == 1'b0, "R1 pulse low in reset", int'(div_pulse), 0);
    @(negedge clk);
    rst = 1'b0;
    gap(n);
    check(n == 1026, "R1 R4 first period after reset with clamp", n, 1026);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule